// File: doc/BRIEF.md
# Lane Loopback and Receive Polarity Controller

This block sits between the MAC and the encode/decode path of a single PHY lane. It chooses what the transmitter sends. In normal operation it sends the code supplied by the MAC. In loopback it sends the lane's own received code, echoed back. The received code is always passed on to the MAC, whether or not loopback is active. A per-lane invert request flips every bit of the received code first, so the MAC and the echo path both see the corrected polarity.

Loopback can only start in the active power state. To end it, the MAC drops the loopback request and raises the electrical-idle request. The block then stays in a drain phase and keeps echoing. It puts the transmitter into electrical idle only after enough consecutive idle symbols have gone back out. This stops the link partner from losing the tail of its idle ordered set. Outside loopback, the electrical-idle output simply follows the MAC request.

All outputs are registered and update one clock after the inputs are sampled. Reset is synchronous and active high.

Top module: `lane_loopback_ctrl`

## Requirements
- R1: Loopback starts at a clock edge where `pwr_state` equals the active code 2'b00 and `lpbk_req` is high. From that edge on, `lpbk_active` reads 1.
- R2: At every edge that leaves the block in loopback or drain, `tx_code` takes the polarity-corrected received code. At every edge that leaves it in normal mode, `tx_code` takes `tx_mac`.
- R3: At every edge and in every mode, `rx_to_mac` takes the polarity-corrected received code.
- R4: When `rx_inv` is high, the corrected code is the bitwise inverse of all 10 bits of `rx_code`, and the echo path uses this inverted code as well. When `rx_inv` is low, the code passes unchanged.
- R5: In loopback, an edge with `lpbk_req` low and `idle_req` high moves the block to drain, where echoing continues. The block leaves drain only at an edge where `idle_req` is high and at least 3 consecutive idle symbols have already been echoed. At that edge `tx_elec_idle` becomes 1, `lpbk_active` becomes 0, and `tx_code` returns to `tx_mac`. The idle symbol is the corrected code 10'b0011110100 or 10'b1100001011.
- R6: Echoing any corrected code other than the two idle symbols restarts the idle count at zero.
- R7: When `pwr_state` is not 2'b00, `lpbk_req` is ignored. If the power state leaves 2'b00 during loopback or drain, the block returns to normal mode at the next edge.
- R8: In normal mode, `tx_elec_idle` follows `idle_req` with one cycle of delay.
- R9: Reset gives `lpbk_active`=0, `tx_elec_idle`=1, and zero on both code outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_state | input | 2 | Power state code from the MAC; 2'b00 is the active state |
| lpbk_req | input | 1 | Loopback request from the MAC |
| idle_req | input | 1 | Transmit electrical-idle request from the MAC |
| rx_inv | input | 1 | Invert the received code |
| rx_code | input | 10 | Received 10-bit code from the deserialiser |
| tx_mac | input | 10 | 10-bit code the MAC wants to send |
| rx_to_mac | output | 10 | Polarity-corrected received code, registered |
| tx_code | output | 10 | Code handed to the serialiser, registered |
| tx_elec_idle | output | 1 | Transmitter electrical idle, registered |
| lpbk_active | output | 1 | High in loopback or drain |

## Verification
The bench tries to start loopback outside the active power state. A design that failed to gate on power state would begin echoing there. The bench requests exit after only two idle symbols, then breaks the run with a data symbol. A design that acted on the request at once, or counted idle symbols cumulatively, would idle the transmitter early. It feeds idle symbols of both polarities, some through the inverter, so a match on a single code or on the uncorrected input would miss the count. It also drops the power state during loopback and resets during loopback, which exposes a design that stays stuck echoing.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_LOOP   = 2'd1,
    ST_DRAIN  = 2'd2
  } mode_e;
endpackage

// File: rtl/lpc_rx_polarity.sv
module lpc_rx_polarity #(
  parameter int SYM_W = 10
) (
  input  logic [SYM_W-1:0] rx_code,
  input  logic             rx_inv,
  output logic [SYM_W-1:0] rx_fix
);
  // per-bit conditional inversion
  for (genvar b = 0; b < SYM_W; b++) begin : g_bit
    assign rx_fix[b] = rx_code[b] ^ rx_inv;
  end
endmodule

// File: rtl/lpc_idle_counter.sv
module lpc_idle_counter #(
  parameter int              SYM_W    = 10,
  parameter int              MIN_IDLE = 3,
  parameter logic [SYM_W-1:0] IDLE_N  = 10'b0011110100,
  parameter logic [SYM_W-1:0] IDLE_P  = 10'b1100001011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             echo_en,
  input  logic [SYM_W-1:0] echo_sym,
  output logic             enough
);
  localparam int CNT_W = $clog2(MIN_IDLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_IDLE);

  logic [CNT_W-1:0] cnt;
  logic             is_idle;

  assign is_idle = (echo_sym == IDLE_N) || (echo_sym == IDLE_P);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!echo_en || !is_idle) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign enough = (cnt == CNT_MAX);

  // R6: a non-idle echo leaves the count below the threshold
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (echo_en && !is_idle) |=> !enough);
endmodule

// File: rtl/lpc_mode_fsm.sv
module lpc_mode_fsm
  import lpc_pkg::*;
#(
  parameter int              PWR_W   = 2,
  parameter logic [PWR_W-1:0] P0_CODE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PWR_W-1:0] pwr_state,
  input  logic             lpbk_req,
  input  logic             idle_req,
  input  logic             enough,
  output mode_e            mode_q,
  output mode_e            mode_d,
  output logic             drain_done
);
  logic in_p0;
  assign in_p0 = (pwr_state == P0_CODE);

  always_comb begin
    mode_d     = mode_q;
    drain_done = 1'b0;
    if (!in_p0) begin
      mode_d = ST_NORMAL;
    end else begin
      unique case (mode_q)
        ST_NORMAL: if (lpbk_req) mode_d = ST_LOOP;
        ST_LOOP:   if (!lpbk_req && idle_req) mode_d = ST_DRAIN;
        ST_DRAIN: begin
          if (idle_req && enough) begin
            mode_d     = ST_NORMAL;
            drain_done = 1'b1;
          end
        end
        default: mode_d = ST_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= ST_NORMAL;
    else     mode_q <= mode_d;
  end

  // R1: loopback is only entered from normal with request in P0
  a_r1_enter_p0: assert property (@(posedge clk) disable iff (rst)
    (mode_q == ST_NORMAL && mode_d != ST_NORMAL) |-> (in_p0 && lpbk_req));

  // R7: outside P0 the next mode is normal
  a_r7_leave_p0: assert property (@(posedge clk) disable iff (rst)
    !in_p0 |=> (mode_q == ST_NORMAL));

  // R5: drain only finishes once the idle count is met
  a_r5_drain_gate: assert property (@(posedge clk) disable iff (rst)
    (mode_q == ST_DRAIN && mode_d == ST_NORMAL && in_p0) |-> enough);
endmodule

// File: rtl/lane_loopback_ctrl.sv
module lane_loopback_ctrl
  import lpc_pkg::*;
#(
  parameter int SYM_W    = 10,
  parameter int PWR_W    = 2,
  parameter int MIN_IDLE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PWR_W-1:0] pwr_state,
  input  logic             lpbk_req,
  input  logic             idle_req,
  input  logic             rx_inv,
  input  logic [SYM_W-1:0] rx_code,
  input  logic [SYM_W-1:0] tx_mac,
  output logic [SYM_W-1:0] rx_to_mac,
  output logic [SYM_W-1:0] tx_code,
  output logic             tx_elec_idle,
  output logic             lpbk_active
);
  logic [SYM_W-1:0] rx_fix;
  logic             enough;
  logic             drain_done;
  logic             echo_en;
  mode_e            mode_q, mode_d;

  lpc_rx_polarity #(.SYM_W(SYM_W)) u_pol (
    .rx_code (rx_code),
    .rx_inv  (rx_inv),
    .rx_fix  (rx_fix)
  );

  lpc_mode_fsm #(.PWR_W(PWR_W), .P0_CODE('0)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .pwr_state  (pwr_state),
    .lpbk_req   (lpbk_req),
    .idle_req   (idle_req),
    .enough     (enough),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .drain_done (drain_done)
  );

  assign echo_en = (mode_d != ST_NORMAL);

  lpc_idle_counter #(.SYM_W(SYM_W), .MIN_IDLE(MIN_IDLE)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .echo_en  (echo_en),
    .echo_sym (rx_fix),
    .enough   (enough)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_to_mac    <= '0;
      tx_code      <= '0;
      tx_elec_idle <= 1'b1;
    end else begin
      rx_to_mac    <= rx_fix;
      tx_code      <= echo_en ? rx_fix : tx_mac;
      tx_elec_idle <= drain_done | (!echo_en && idle_req);
    end
  end

  assign lpbk_active = (mode_q != ST_NORMAL);

  // R2: while looping, transmit carries the previous corrected receive code
  a_r2_echo: assert property (@(posedge clk) disable iff (rst)
    lpbk_active |-> (tx_code == rx_to_mac));

  // R5: transmitter never idles while the loop is still active
  a_r5_no_idle_in_loop: assert property (@(posedge clk) disable iff (rst)
    lpbk_active |-> !tx_elec_idle);
endmodule

// File: tb/test_lane_loopback_ctrl.sv
module test_lane_loopback_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] pwr_state;
  logic       lpbk_req, idle_req, rx_inv;
  logic [9:0] rx_code, tx_mac;
  logic [9:0] rx_to_mac, tx_code;
  logic       tx_elec_idle, lpbk_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  lane_loopback_ctrl i_lane_loopback_ctrl (
    .clk(clk), .rst(rst), .pwr_state(pwr_state), .lpbk_req(lpbk_req),
    .idle_req(idle_req), .rx_inv(rx_inv), .rx_code(rx_code), .tx_mac(tx_mac),
    .rx_to_mac(rx_to_mac), .tx_code(tx_code), .tx_elec_idle(tx_elec_idle),
    .lpbk_active(lpbk_active)
  );

  localparam logic [9:0] IDN = 10'b0011110100;
  localparam logic [9:0] IDP = 10'b1100001011;
  localparam logic [9:0] DA  = 10'h155;
  localparam logic [9:0] DAI = 10'h2AA;
  localparam logic [9:0] DB  = 10'h0C3;
  localparam logic [9:0] M1  = 10'h111;
  localparam logic [9:0] M2  = 10'h222;

  // {pwr, lpbk, idle, inv, rx, txm, exp_rx, exp_tx, exp_eidle, exp_act}
  localparam int NV = 14;
  localparam logic [46:0] VEC [NV] = '{
    {2'd1, 1'b1, 1'b0, 1'b0, DA,  M1, DA,  M1, 1'b0, 1'b0},  // R7 request ignored in P1
    {2'd0, 1'b0, 1'b1, 1'b1, DA,  M1, DAI, M1, 1'b1, 1'b0},  // R8 idle follows, R4 invert
    {2'd0, 1'b1, 1'b0, 1'b0, DB,  M2, DB,  DB, 1'b0, 1'b1},  // R1 enter, R2 echo
    {2'd0, 1'b1, 1'b0, 1'b1, DA,  M2, DAI, DAI,1'b0, 1'b1},  // R4 inverted echo
    {2'd0, 1'b0, 1'b1, 1'b0, IDN, M2, IDN, IDN,1'b0, 1'b1},  // R5 to drain, count 1
    {2'd0, 1'b0, 1'b1, 1'b0, IDN, M2, IDN, IDN,1'b0, 1'b1},  // R5 count 2, no exit
    {2'd0, 1'b0, 1'b1, 1'b0, DA,  M2, DA,  DA, 1'b0, 1'b1},  // R6 restart count
    {2'd0, 1'b0, 1'b1, 1'b0, IDN, M2, IDN, IDN,1'b0, 1'b1},  // count 1
    {2'd0, 1'b0, 1'b1, 1'b0, IDP, M2, IDP, IDP,1'b0, 1'b1},  // count 2, other polarity
    {2'd0, 1'b0, 1'b1, 1'b1, IDP, M2, IDN, IDN,1'b0, 1'b1},  // count 3 via inverter
    {2'd0, 1'b0, 1'b1, 1'b0, DB,  M1, DB,  M1, 1'b1, 1'b0},  // R5 exit done
    {2'd0, 1'b0, 1'b0, 1'b0, DA,  M2, DA,  M2, 1'b0, 1'b0},  // R8 normal
    {2'd0, 1'b1, 1'b0, 1'b0, DA,  M2, DA,  DA, 1'b0, 1'b1},  // R1 re-enter
    {2'd2, 1'b1, 1'b0, 1'b0, DB,  M1, DB,  M1, 1'b0, 1'b0}   // R7 power leaves P0
  };

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [46:0] v);
    pwr_state = v[46:45];
    lpbk_req  = v[44];
    idle_req  = v[43];
    rx_inv    = v[42];
    rx_code   = v[41:32];
    tx_mac    = v[31:22];
  endtask

  task automatic check_reset();
    chk("R9 lpbk_active", {9'd0, lpbk_active}, 10'd0);
    chk("R9 tx_elec_idle", {9'd0, tx_elec_idle}, 10'd1);
    chk("R9 tx_code", tx_code, 10'd0);
    chk("R9 rx_to_mac", rx_to_mac, 10'd0);
  endtask

  initial begin
    rst = 1'b1;
    drive({2'd0, 1'b0, 1'b0, 1'b0, 10'd0, 10'd0, 20'd0, 2'd0});
    repeat (3) @(posedge clk);
    #5;
    check_reset();
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      #5;
      chk("R3/R4 rx_to_mac", rx_to_mac, VEC[i][21:12]);
      chk("R2 tx_code", tx_code, VEC[i][11:2]);
      chk("R5/R8 tx_elec_idle", {9'd0, tx_elec_idle}, {9'd0, VEC[i][1]});
      chk("R1/R7 lpbk_active", {9'd0, lpbk_active}, {9'd0, VEC[i][0]});
      @(negedge clk);
    end

    // reset during loopback returns to the reset state (R9)
    drive({2'd0, 1'b1, 1'b0, 1'b0, DA, M1, 20'd0, 2'd0});
    @(posedge clk); #5;
    chk("R1 lpbk_active before reset", {9'd0, lpbk_active}, 10'd1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #5;
    check_reset();
    @(negedge clk);
    rst = 1'b0;

    // R5: exit request with idle codes but the drain must wait 3 echoes
    drive({2'd0, 1'b1, 1'b0, 1'b0, DB, M1, 20'd0, 2'd0});
    @(posedge clk); #5;
    @(negedge clk);
    drive({2'd0, 1'b0, 1'b1, 1'b0, IDN, M1, 20'd0, 2'd0});
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #5;
      chk("R5 no early idle", {9'd0, tx_elec_idle}, 10'd0);
      @(negedge clk);
    end
    @(posedge clk); #5;
    chk("R5 idle after 3 echoes", {9'd0, tx_elec_idle}, 10'd1);
    chk("R5 tx back to MAC", tx_code, M1);
    chk("R5 loop ended", {9'd0, lpbk_active}, 10'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule